// File: doc/BRIEF.md
# Message Schedule Finishing Stage (four words, chained)

This unit produces the next four 64-bit words of the SHA-512 message schedule from two 256-bit operands. The first operand, `part_sum`, carries four partial sums, one per lane. A preceding scheduling step and an external adder for the t-7 terms would normally form them. The second operand, `recent`, carries the two newest schedule words in its upper two lanes. Its lower two lanes are ignored. Lane i of a 256-bit bus is bits [64*i+63 : 64*i].

Each lane adds the small sigma-1 of an older word to its partial sum. In the two upper lanes that older word is a result made in the same operation, so lane 2 depends on lane 0 and lane 3 depends on lane 1. This makes the adder path serial.

The `LAT_MODE` parameter chooses the latency. `LAT_ONE` finishes the operation in one cycle. `LAT_TWO` puts a register between the lower pair and the upper pair. Results leave through a single output register under a valid/ready handshake. No new operand is taken while a result is pending or in flight.

Top module: `sched_word_finish`

## Requirements
- R1: Small sigma-1 of x is rotr(x,19) XOR rotr(x,61) XOR (x logically shifted right by 6). Output lane 0 equals part lane 0 plus sigma-1(recent lane 2), modulo 2^64.
- R2: Output lane 1 equals part lane 1 plus sigma-1(recent lane 3), modulo 2^64.
- R3: Output lane 2 equals part lane 2 plus sigma-1(output lane 0). Output lane 3 equals part lane 3 plus sigma-1(output lane 1). Both sums are modulo 2^64 and use the results of the same operation.
- R4: Lanes 0 and 1 of `recent` have no effect on any output.
- R5: `out_valid` rises 1 clock edge after the accepting edge (`in_valid` and `in_ready` both high) in `LAT_ONE`. In `LAT_TWO` it rises 2 edges after the accepting edge.
- R6: `in_ready` is low while an operation is in flight or `out_valid` is high. An operand offered while `in_ready` is low is not taken and never shows up at the output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_words` stays unchanged. An edge with both high clears `out_valid`.
- R8: After synchronous reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Unit can take operands this edge |
| part_sum | input | 256 | Four partial sums, lane i at bits 64i+63:64i |
| recent | input | 256 | Lanes 2 and 3 are the two newest schedule words; lanes 0 and 1 are ignored |
| out_valid | output | 1 | Result register holds a finished result |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_words | output | 256 | Four new schedule words, lane 0 first |

## Verification
The hardest case to reach is a fault in the chained upper lanes that only shows when a single bit of an older word passes through two sigma-1 steps and a carry. A bit that is wrong in lane 0 reaches lane 2 only after rotation, shift and addition. For this, the stimulus walks a single set bit and a single cleared bit across every position of the two newest words. It pairs these with partial sums that force wrap-around carries. Backpressure and operands offered while busy are applied on every operation, so the stall path is exercised on every one of them.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned LANES = 4;
  typedef enum logic {
    LAT_ONE = 1'b0,
    LAT_TWO = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/sched_sig1.sv
module sched_sig1 #(
  parameter int unsigned W    = 64,
  parameter int unsigned ROTA = 19,
  parameter int unsigned ROTB = 61,
  parameter int unsigned SHF  = 6
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] r_a, r_b, s_c;
  assign r_a = (x >> ROTA) | (x << (W - ROTA));
  assign r_b = (x >> ROTB) | (x << (W - ROTB));
  assign s_c = x >> SHF;
  assign y   = r_a ^ r_b ^ s_c;
endmodule

// File: rtl/sched_pair_stage.sv
module sched_pair_stage #(
  parameter int unsigned W    = 64,
  parameter int unsigned ROTA = 19,
  parameter int unsigned ROTB = 61,
  parameter int unsigned SHF  = 6
) (
  input  logic [2*W-1:0] base,
  input  logic [2*W-1:0] src,
  output logic [2*W-1:0] sum
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [W-1:0] sg;
    sched_sig1 #(.W(W), .ROTA(ROTA), .ROTB(ROTB), .SHF(SHF)) u_sig (
      .x(src[g*W +: W]),
      .y(sg)
    );
    assign sum[g*W +: W] = base[g*W +: W] + sg;
  end
endmodule

// File: rtl/sched_word_finish.sv
module sched_word_finish #(
  parameter int unsigned         W        = 64,
  parameter int unsigned         ROTA     = 19,
  parameter int unsigned         ROTB     = 61,
  parameter int unsigned         SHF      = 6,
  parameter sched_pkg::lat_mode_e LAT_MODE = sched_pkg::LAT_ONE
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [sched_pkg::LANES*W-1:0] part_sum,
  input  logic [sched_pkg::LANES*W-1:0] recent,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [sched_pkg::LANES*W-1:0] out_words
);
  localparam int unsigned BUS_W  = sched_pkg::LANES * W;
  localparam int unsigned PAIR_W = 2 * W;

  logic              accept;
  logic [PAIR_W-1:0] lo_sum;
  logic [PAIR_W-1:0] s2_lo, s2_base, hi_sum;
  logic              s2_load;
  logic              mid_valid;

  assign accept = in_valid && in_ready;

  sched_pair_stage #(.W(W), .ROTA(ROTA), .ROTB(ROTB), .SHF(SHF)) u_lo (
    .base(part_sum[PAIR_W-1:0]),
    .src (recent[BUS_W-1:PAIR_W]),
    .sum (lo_sum)
  );

  if (LAT_MODE == sched_pkg::LAT_TWO) begin : g_two
    logic [PAIR_W-1:0] mid_lo, mid_base;
    logic              mid_v;
    always_ff @(posedge clk) begin
      if (rst) begin
        mid_v <= 1'b0;
      end else if (accept) begin
        mid_v <= 1'b1;
      end else begin
        mid_v <= 1'b0;
      end
      if (accept) begin
        mid_lo   <= lo_sum;
        mid_base <= part_sum[BUS_W-1:PAIR_W];
      end
    end
    assign mid_valid = mid_v;
    assign s2_lo     = mid_lo;
    assign s2_base   = mid_base;
    assign s2_load   = mid_v;
    assign in_ready  = !out_valid && !mid_v;
  end else begin : g_one
    assign mid_valid = 1'b0;
    assign s2_lo     = lo_sum;
    assign s2_base   = part_sum[BUS_W-1:PAIR_W];
    assign s2_load   = accept;
    assign in_ready  = !out_valid;
  end

  sched_pair_stage #(.W(W), .ROTA(ROTA), .ROTB(ROTB), .SHF(SHF)) u_hi (
    .base(s2_base),
    .src (s2_lo),
    .sum (hi_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (s2_load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
    if (s2_load) begin
      out_words <= {hi_sum, s2_lo};
    end
  end

  function automatic logic [W-1:0] chk_sig(input logic [W-1:0] v);
    logic [2*W-1:0] d;
    d = {v, v};
    return d[ROTA +: W] ^ d[ROTB +: W] ^ (v >> SHF);
  endfunction

  assert_reset_R8: assert property (@(posedge clk) rst |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_words));

  assert_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid || mid_valid) |-> !in_ready);

  if (LAT_MODE == sched_pkg::LAT_TWO) begin : g_chk_two
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      accept |=> !out_valid ##1 out_valid);
    assert_chain_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |->
        out_words[2*W +: W] == $past(part_sum[2*W +: W], 2) + chk_sig(out_words[0 +: W]) &&
        out_words[3*W +: W] == $past(part_sum[3*W +: W], 2) + chk_sig(out_words[W +: W]));
    assert_low_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |->
        out_words[0 +: W] == $past(part_sum[0 +: W], 2) + chk_sig($past(recent[2*W +: W], 2)));
  end else begin : g_chk_one
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      accept |=> out_valid);
    assert_chain_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |->
        out_words[2*W +: W] == $past(part_sum[2*W +: W]) + chk_sig(out_words[0 +: W]) &&
        out_words[3*W +: W] == $past(part_sum[3*W +: W]) + chk_sig(out_words[W +: W]));
    assert_low_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |->
        out_words[0 +: W] == $past(part_sum[0 +: W]) + chk_sig($past(recent[2*W +: W])));
  end
endmodule

// File: tb/test_sched_word_finish.sv
module test_sched_word_finish;
  localparam int W = 64;
  localparam int BW = 4 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] part_sum = '0;
  logic [BW-1:0] recent = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [BW-1:0] out_words;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sched_word_finish #(.LAT_MODE(sched_pkg::LAT_TWO)) i_sched_word_finish (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .part_sum(part_sum), .recent(recent), .out_valid(out_valid),
    .out_ready(out_ready), .out_words(out_words)
  );

  function automatic logic [W-1:0] ref_s1(input logic [W-1:0] x);
    logic [W-1:0] r19, r61;
    for (int i = 0; i < W; i++) begin
      r19[i] = x[(i + 19) % W];
      r61[i] = x[(i + 61) % W];
    end
    return r19 ^ r61 ^ (x >> 6);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [W-1:0] e0, e1, e2, e3;
    logic [BW-1:0] held;
    e0 = a[0 +: W] + ref_s1(b[2*W +: W]);
    e1 = a[W +: W] + ref_s1(b[3*W +: W]);
    e2 = a[2*W +: W] + ref_s1(e0);
    e3 = a[3*W +: W] + ref_s1(e1);
    @(negedge clk);
    chk("R6 ready before op", {63'd0, in_ready}, 64'd1);
    part_sum = a; recent = b; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    // R6: operand offered while busy must be dropped
    part_sum = ~a; recent = ~b;
    chk("R5 not yet valid", {63'd0, out_valid}, 64'd0);
    chk("R6 busy in flight", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    chk("R5 valid after two edges", {63'd0, out_valid}, 64'd1);
    chk("R1 lane0", out_words[0 +: W], e0);
    chk("R2 lane1", out_words[W +: W], e1);
    chk("R3 lane2", out_words[2*W +: W], e2);
    chk("R3 lane3", out_words[3*W +: W], e3);
    held = out_words;
    @(negedge clk);
    chk("R7 held valid", {63'd0, out_valid}, 64'd1);
    chk("R7 held lane0", out_words[0 +: W], held[0 +: W]);
    chk("R7 held lane3", out_words[3*W +: W], held[3*W +: W]);
    chk("R6 busy pending", {63'd0, in_ready}, 64'd0);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 drained", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R6 dropped operand absent", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] one_hot;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R8 in_ready after reset", {63'd0, in_ready}, 64'd1);
    for (int p = 0; p < W; p++) begin
      one_hot = 64'd1 << p;
      // R4: lanes 0/1 of recent carry varying junk that must not matter
      do_op({64'h0123_4567_89ab_cdef ^ one_hot, ~one_hot, 64'hffff_ffff_ffff_ffff, 64'(p) * 64'h9e37_79b9_7f4a_7c15},
            {one_hot, ~one_hot, {32'(p), 32'hdead_beef}, ~one_hot});
    end
    do_op('0, '0);
    do_op({BW{1'b1}}, {BW{1'b1}});
    do_op({BW{1'b1}}, {128'h8000_0000_0000_0001_0000_0000_0000_0040, 128'd0});
    // R4 explicit: same operation, different ignored lanes
    do_op({4{64'h5555_aaaa_3333_cccc}}, {128'h0f0f_f0f0_1234_5678_8765_4321_abcd_ef01, 128'd0});
    do_op({4{64'h5555_aaaa_3333_cccc}}, {128'h0f0f_f0f0_1234_5678_8765_4321_abcd_ef01, {128{1'b1}}});
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule